// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block sequences an 8-bit successive-approximation conversion. It reacts to either of two start sources: a falling edge on a dedicated start strobe, or chip-select and read becoming active together. It moves the track/hold control into hold for as long as the conversion runs. It presents a trial code to the converter's internal DAC, one bit per conversion clock with the most significant bit first. It samples a comparator bit that reports whether the analog input is at or above the trial level. When the last bit has been decided, the result is copied into an output latch and the trial register is cleared.

Completion is reported on an active-low busy line and an active-low interrupt. Reading the latch releases the interrupt, and so does a dedicated interrupt-clear input. That input leaves a conversion in progress alone. The latch is put onto a three-state data bus only while chip-select and read are both low. Every action is synchronous to one clock, which also acts as the conversion clock, and the design uses a synchronous active-high reset.

Top module: `sar_seq_top`

## Requirements
- R1: A falling edge on `start_n`, seen while idle (`busy_n` = 1), starts a conversion. `busy_n` reads 0 after the clock edge that samples the falling edge.
- R2: `cs_n` and `rd_n` becoming low together while idle also start a conversion, with the same timing as R1.
- R3: `hold` is 1 exactly while a conversion runs (`busy_n` = 0) and is 0 once `busy_n` has returned high.
- R4: A conversion keeps `busy_n` low for exactly 8 clock cycles. On the eighth clock edge after the start edge, `busy_n` returns high and the result enters the latch.
- R5: The trial code is 8'h80 after the start edge. Each later edge handles the current bit: the bit stays set if `cmp_in` is 1 and is cleared if `cmp_in` is 0, and the next lower bit is then set. The most significant bit is therefore decided on the second edge counted from the one that sees the start.
- R6: At the end of a conversion the trial code returns to 8'h00.
- R7: `int_n` goes to 0 on the same edge that loads the output latch.
- R8: A read (`cs_n` and `rd_n` becoming low together) sets `int_n` back to 1 on the following edge.
- R9: A pulse on `int_clr` sets `int_n` to 1 on the following edge. It does not change the length or the result of a conversion in progress.
- R10: Conversions started back to back without clearing the interrupt still produce correct results in the latch.
- R11: A start request of either kind made while `busy_n` is 0 is ignored. No further conversion follows the one already running.
- R12: `bus_oe` is 1, and `bus_d` carries the latch contents, only while `cs_n` and `rd_n` are both 0. Otherwise `bus_oe` is 0 and `bus_d` is high-impedance.
- R13: After reset, `busy_n` = 1, `int_n` = 1, `hold` = 0, the trial code is 8'h00 and the latch holds 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Dedicated start strobe; active on its falling edge |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| int_clr | input | 1 | Releases the interrupt; leaves a running conversion untouched |
| cmp_in | input | 1 | Comparator result: 1 when the input is at or above the trial level |
| trial | output | 8 | Trial code sent to the internal DAC |
| hold | output | 1 | Track/hold control: 1 = hold, 0 = track |
| busy_n | output | 1 | Low while a conversion runs |
| int_n | output | 1 | Active-low end-of-conversion interrupt |
| bus_oe | output | 1 | Data bus drive enable |
| bus_d | output | 8 | Three-state data bus carrying the result latch |

## Verification
Start strobes are applied at the falling clock edge. `busy_n`, `hold` and the 8'h80 trial code are expected after the very next rising edge. The most significant bit decision is expected one edge later. The bench samples at the falling edge that follows each counted rising edge, so it observes every register exactly once. It expects `busy_n` still low after edge 7 and high, with `int_n` low and the trial cleared, after edge 8. Bus outputs depend only on the strobes, so they are checked 1 ns after the strobes are applied. Interrupt release from a read or from `int_clr` is checked one edge later.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int CODE_W = 8;

    typedef enum logic {
        PH_TRACK = 1'b0,
        PH_HOLD  = 1'b1
    } phase_e;

    typedef struct packed {
        logic strobe_fall;
        logic read_fall;
    } start_ev_t;

endpackage

// File: rtl/sar_start_detect.sv
module sar_start_detect
    import sar_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_n,
    input  logic      cs_n,
    input  logic      rd_n,
    output logic      rd_act,
    output start_ev_t ev
);
    logic st_q;
    logic rd_q;

    assign rd_act = ~cs_n & ~rd_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= 1'b1;
            rd_q <= 1'b0;
        end else begin
            st_q <= start_n;
            rd_q <= rd_act;
        end
    end

    assign ev.strobe_fall = st_q & ~start_n;
    assign ev.read_fall   = rd_act & ~rd_q;
endmodule

// File: rtl/sar_core.sv
module sar_core
    import sar_seq_pkg::*;
#(
    parameter int W = CODE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_req,
    input  logic         cmp_in,
    output logic [W-1:0] trial,
    output phase_e       phase,
    output logic         done,
    output logic [W-1:0] result
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);
    localparam logic [W-1:0]  ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0]  MSB  = ONE << (W - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] idx;
    logic [W-1:0]  mask;
    logic [W-1:0]  nxt;
    logic          last;

    assign idx  = LAST - cnt;
    assign mask = ONE << idx;
    assign last = (cnt == LAST);

    always_comb begin
        nxt = cmp_in ? trial : (trial & ~mask);
        if (!last) nxt = nxt | (mask >> 1);
    end

    assign done   = (phase == PH_HOLD) && last;
    assign result = nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_TRACK;
            cnt   <= '0;
            trial <= '0;
        end else if (phase == PH_HOLD) begin
            if (last) begin
                phase <= PH_TRACK;
                cnt   <= '0;
                trial <= '0;
            end else begin
                cnt   <= cnt + 1'b1;
                trial <= nxt;
            end
        end else if (start_req) begin
            phase <= PH_HOLD;
            cnt   <= '0;
            trial <= MSB;
        end
    end
endmodule

// File: rtl/sar_out_ctrl.sv
module sar_out_ctrl #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         done,
    input  logic [W-1:0] result,
    input  logic         rd_act,
    input  logic         rd_fall,
    input  logic         int_clr,
    output logic         int_n,
    output logic         bus_oe,
    output logic [W-1:0] bus_d
);
    logic [W-1:0] latch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            int_n   <= 1'b1;
        end else begin
            if (done) latch_q <= result;
            if (done)                      int_n <= 1'b0;
            else if (rd_fall || int_clr)   int_n <= 1'b1;
        end
    end

    assign bus_oe = rd_act;
    assign bus_d  = rd_act ? latch_q : {W{1'bz}};
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int W = CODE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_n,
    input  logic         cs_n,
    input  logic         rd_n,
    input  logic         int_clr,
    input  logic         cmp_in,
    output logic [W-1:0] trial,
    output logic         hold,
    output logic         busy_n,
    output logic         int_n,
    output logic         bus_oe,
    output logic [W-1:0] bus_d
);
    start_ev_t    ev;
    logic         rd_act;
    logic         done;
    logic [W-1:0] result;
    phase_e       phase;

    sar_start_detect u_det (
        .clk     (clk),
        .rst     (rst),
        .start_n (start_n),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .rd_act  (rd_act),
        .ev      (ev)
    );

    sar_core #(.W(W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .start_req (ev.strobe_fall | ev.read_fall),
        .cmp_in    (cmp_in),
        .trial     (trial),
        .phase     (phase),
        .done      (done),
        .result    (result)
    );

    sar_out_ctrl #(.W(W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .done    (done),
        .result  (result),
        .rd_act  (rd_act),
        .rd_fall (ev.read_fall),
        .int_clr (int_clr),
        .int_n   (int_n),
        .bus_oe  (bus_oe),
        .bus_d   (bus_d)
    );

    assign hold   = (phase == PH_HOLD);
    assign busy_n = (phase == PH_TRACK);
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         cs_n,
    input logic         rd_n,
    input logic         int_clr,
    input logic [W-1:0] trial,
    input logic         busy_n,
    input logic         int_n
);
    localparam int BW = $clog2(W + 2);
    localparam logic [W-1:0] MSB = {1'b1, {(W-1){1'b0}}};

    logic [BW-1:0] bcnt;

    always_ff @(posedge clk) begin
        if (rst)          bcnt <= '0;
        else if (!busy_n) bcnt <= bcnt + 1'b1;
        else              bcnt <= '0;
    end

    // R5
    msb_first_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_n) |-> trial == MSB);

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_n) |-> bcnt == BW'(W));

    // R11
    busy_bound_chk: assert property (@(posedge clk) disable iff (rst)
        bcnt <= BW'(W));

    // R7
    int_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(int_n) |-> $rose(busy_n));

    // R9
    iclr_chk: assert property (@(posedge clk) disable iff (rst)
        (int_clr && !busy_n && bcnt < BW'(W - 1)) |=> (!busy_n && int_n));

    // R8
    int_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(int_n) |-> ($past(int_clr) || $past(!cs_n && !rd_n)));
endmodule

bind sar_seq_top sar_seq_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .int_clr (int_clr),
    .trial   (trial),
    .busy_n  (busy_n),
    .int_n   (int_n)
);

// File: tb/test_sar_seq_top.sv
`timescale 1ns/1ps
module test_sar_seq_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_n = 1'b1;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       int_clr = 1'b0;
    logic [7:0] vin = 8'h00;
    logic       cmp_in;
    logic [7:0] trial;
    logic       hold, busy_n, int_n, bus_oe;
    wire  [7:0] bus_d;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    // comparator model: input at or above trial level
    assign cmp_in = (vin >= trial);

    sar_seq_top i_sar_seq_top (
        .clk(clk), .rst(rst), .start_n(start_n), .cs_n(cs_n), .rd_n(rd_n),
        .int_clr(int_clr), .cmp_in(cmp_in), .trial(trial), .hold(hold),
        .busy_n(busy_n), .int_n(int_n), .bus_oe(bus_oe), .bus_d(bus_d)
    );

    // bit 8: 1 = start via cs/rd, 0 = start via start_n; bits 7:0 = input level
    localparam logic [8:0] VEC [6] = '{
        9'h0_00, 9'h1_FF, 9'h0_80, 9'h1_7F, 9'h0_A5, 9'h1_5A
    };

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic start_conv(input bit via_rd);
        if (via_rd) begin cs_n = 1'b0; rd_n = 1'b0; end
        else        start_n = 1'b0;
        tick;
        cs_n = 1'b1; rd_n = 1'b1; start_n = 1'b1;
    endtask

    // reads the latch (which also starts a conversion) and waits it out
    task automatic read_latch(input string tag, input logic [7:0] exp);
        cs_n = 1'b0; rd_n = 1'b0;
        #1;
        chk({tag, " R12 oe"}, bus_oe, 1);
        chk({tag, " R12 data"}, bus_d, exp);
        @(negedge clk);
        tick;
        cs_n = 1'b1; rd_n = 1'b1;
        chk({tag, " R8 int released"}, int_n, 1);
        chk({tag, " R2 read start"}, busy_n, 0);
        repeat (8) tick;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick;
        rst = 1'b0;
        tick;
        // R13 reset state
        chk("R13 busy_n", busy_n, 1);
        chk("R13 int_n", int_n, 1);
        chk("R13 hold", hold, 0);
        chk("R13 trial", trial, 8'h00);
        cs_n = 1'b0; rd_n = 1'b0; #1;
        chk("R13 latch", bus_d, 8'h00);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
        tick;
        repeat (9) tick;

        // table-driven conversions
        for (int i = 0; i < 6; i++) begin
            logic [7:0] e1;
            vin = VEC[i][7:0];
            e1  = (vin >= 8'h80 ? 8'h80 : 8'h00) | 8'h40;
            start_conv(VEC[i][8]);
            chk(VEC[i][8] ? "R2 start" : "R1 start", busy_n, 0);
            chk("R3 hold on", hold, 1);
            chk("R5 first trial", trial, 8'h80);
            tick;
            chk("R5 msb decision", trial, e1);
            repeat (6) tick;
            chk("R4 still busy", busy_n, 0);
            tick;
            chk("R4 done", busy_n, 1);
            chk("R7 int low", int_n, 0);
            chk("R6 trial clear", trial, 8'h00);
            chk("R3 hold off", hold, 0);
            read_latch("R5 result", vin);
        end

        // R11: start during conversion ignored
        vin = 8'h33;
        start_conv(1'b0);
        repeat (3) tick;
        start_n = 1'b0; tick; start_n = 1'b1;
        cs_n = 1'b0; rd_n = 1'b0; tick; cs_n = 1'b1; rd_n = 1'b1;
        repeat (3) tick;
        chk("R11 done on time", busy_n, 1);
        tick;
        chk("R11 no extra conversion", busy_n, 1);
        read_latch("R11", 8'h33);

        // R9: int_clr during conversion
        vin = 8'hC8;
        start_conv(1'b0);
        repeat (2) tick;
        int_clr = 1'b1; tick; int_clr = 1'b0;
        chk("R9 int released", int_n, 1);
        chk("R9 still busy", busy_n, 0);
        repeat (4) tick;
        chk("R9 length kept", busy_n, 0);
        tick;
        chk("R9 done", busy_n, 1);
        chk("R9 int again", int_n, 0);
        read_latch("R9", 8'hC8);

        // R10: back to back without clearing interrupt
        vin = 8'h3C;
        start_conv(1'b0);
        repeat (8) tick;
        vin = 8'hC3;
        start_conv(1'b0);
        repeat (8) tick;
        chk("R10 done", busy_n, 1);
        read_latch("R10", 8'hC3);

        // R12: bus stays off unless both strobes low
        cs_n = 1'b0; rd_n = 1'b1; #1;
        chk("R12 cs only", bus_oe, 0);
        cs_n = 1'b1; rd_n = 1'b0; #1;
        chk("R12 rd only", bus_oe, 0);
        rd_n = 1'b1;
        @(negedge clk);

        // R13: reset mid-conversion
        vin = 8'h77;
        start_conv(1'b0);
        repeat (3) tick;
        rst = 1'b1; tick; rst = 1'b0;
        chk("R13 busy after reset", busy_n, 1);
        chk("R13 trial after reset", trial, 8'h00);
        chk("R13 int after reset", int_n, 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule